// File: doc/BRIEF.md
# Shadow Address Gather Engine

This block sits on the bus side of a memory controller and looks at the line-read address of every request. An address below the top of installed DRAM is ordinary memory. It is passed on to the scheduler path on the next cycle and gets no further processing. An address above that point is a shadow address. The block compares it against a small table of descriptors that software loads. The matching descriptor then expands the one cache-line read into a series of word fetches, each at a pseudo-virtual address.

Each descriptor uses one of three mapping modes:
- **Page copy:** the words map contiguously onto a pseudo-virtual page.
- **Strided:** word offset `s` maps to `pv + (s << shift)`.
- **Indirect:** the block first fetches an index table entry for every word, then fetches `pv + (entry << shift)`.

Each stride is a power of two, so the address arithmetic uses only shifts and adds and needs no divider.

Returned words carry their offset tag and may arrive in any order. The block places each one in a buffer owned by the descriptor. Once every word of the line has arrived, it streams the assembled line out in ascending word order. A shadow address that no enabled descriptor covers gets an error pulse and causes no fetch.

Top module: `shadow_remap_engine`

## Requirements
- R1: A request whose address is below `DRAM_TOP` is accepted in one cycle. `phys_valid` is high on the following cycle with `phys_addr` equal to the request address, and no word fetch is issued. This holds even when a descriptor covers that address.
- R2: A request at or above `DRAM_TOP` that no enabled descriptor covers (`lo <= addr < hi`) produces a one-cycle `err_valid` pulse on the following cycle. It produces no `phys_valid` and no fetch, and the block is ready again right after.
- R3: A descriptor matches when it is enabled and `lo <= addr < hi`. When several descriptors match, the one with the lowest index is used. A descriptor with `cfg_en = 0` never matches.
- R4: In page-copy mode (`cfg_mode = 0`), the fetch for word `w` of the line has address `pv + (addr - lo) + 8*w`.
- R5: In strided mode (`cfg_mode = 1`), the fetch for word `w` has address `pv + (s << shift)`, where `s = (addr - lo)/8 + w`. Within a phase, fetches are issued with tags 0 to 15 in ascending order, one per cycle, with `fetch_vec = 0` for data fetches. Exactly 16 are issued.
- R6: In indirect mode (`cfg_mode = 2`), 16 index fetches (`fetch_vec = 1`) are issued first, at `vec + 8*s`. After all 16 have returned, 16 data fetches follow at `pv + (e << shift)`, where `e` is the low 32 bits of the index word returned for that tag. The upper 32 bits of the index word are ignored.
- R7: Returned words (`ret_vec = 0`) may arrive in any order and are placed by `ret_tag`. No line word is output until all 16 words have returned. The line then appears as 16 consecutive beats with `line_idx` 0 to 15, and `line_last` is high only on index 15.
- R8: From the acceptance of a shadow request until after its last line beat, `req_ready` is low and any request presented is neither accepted nor answered.
- R9: The fields of a descriptor are captured when a request is accepted. Rewriting that descriptor during the gather does not change the addresses of that gather, but it does change the addresses of the next request.
- R10: After reset, `req_ready` is high and `phys_valid`, `err_valid`, `fetch_valid` and `line_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the descriptor selected by cfg_sel |
| cfg_sel | input | IDX_W | Descriptor index to write |
| cfg_en | input | 1 | Descriptor enable |
| cfg_mode | input | 2 | 0 page copy, 1 strided, 2 indirect |
| cfg_shift | input | 5 | log2 of the stride in bytes |
| cfg_lo | input | 32 | First shadow byte address covered |
| cfg_hi | input | 32 | First shadow byte address past the region |
| cfg_pv | input | 32 | Pseudo-virtual base of the target object |
| cfg_vec | input | 32 | Base address of the index table |
| req_valid | input | 1 | Line-read request present |
| req_addr | input | 32 | Line-aligned request address |
| req_ready | output | 1 | Block can take a request this cycle |
| phys_valid | output | 1 | Normal-memory address forwarded |
| phys_addr | output | 32 | Forwarded address |
| err_valid | output | 1 | Unmapped shadow address |
| fetch_valid | output | 1 | Word fetch request to the page translator |
| fetch_addr | output | 32 | Pseudo-virtual word address |
| fetch_tag | output | TAG_W | Word offset within the line |
| fetch_vec | output | 1 | 1 for an index fetch, 0 for a data fetch |
| ret_valid | input | 1 | Returned word present |
| ret_tag | input | TAG_W | Tag of the returned word |
| ret_vec | input | 1 | Returned word is an index entry |
| ret_data | input | DATA_W | Returned word |
| line_valid | output | 1 | Assembled line beat |
| line_idx | output | TAG_W | Word index of the beat |
| line_data | output | DATA_W | Word of the line |
| line_last | output | 1 | Final beat of the line |

## Verification
The bench targets the address boundaries of the design:
- A request at exactly `DRAM_TOP` and one just past a region's `hi` must produce an error. A design with an off-by-one compare would instead start a gather or forward the address.
- Overlapping regions show whether the lowest index wins.
- A region that lies below `DRAM_TOP` shows that bypass takes precedence.

Returns are given in permuted and in reversed order. A design that writes words in arrival order, or that releases the line before every word is back, therefore shows shuffled or stale words.

Index words carry a non-zero upper half, to catch arithmetic that uses the full word. Finally, one descriptor is rewritten in the middle of a gather while a stray request is held on the input. This exposes a design that reads live configuration, or one that accepts work while it is busy.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
  localparam int RMP_AW  = 32;
  localparam int RMP_SHW = 5;

  typedef enum logic [1:0] {
    MODE_PAGE   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDIR  = 2'd2
  } rmp_mode_e;

  typedef struct packed {
    logic                en;
    rmp_mode_e           mode;
    logic [RMP_SHW-1:0]  shift;
    logic [RMP_AW-1:0]   lo;
    logic [RMP_AW-1:0]   hi;
    logic [RMP_AW-1:0]   pv;
    logic [RMP_AW-1:0]   vec;
  } rmp_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_VWAIT, ST_DATA, ST_DWAIT, ST_DRAIN
  } rmp_state_e;
endpackage

// File: rtl/rmp_desc_table.sv
module rmp_desc_table import rmp_pkg::*; #(
  parameter int NDESC = 8,
  parameter int IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_sel,
  input  rmp_desc_t        cfg_word,
  input  logic [RMP_AW-1:0] look_addr,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output rmp_desc_t        hit_desc
);
  rmp_desc_t        tbl [NDESC];
  logic [NDESC-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDESC; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      tbl[cfg_sel] <= cfg_word;
    end
  end

  // one range comparator per descriptor
  for (genvar g = 0; g < NDESC; g++) begin : g_cmp
    assign match[g] = tbl[g].en && (look_addr >= tbl[g].lo) && (look_addr < tbl[g].hi);
  end

  // lowest index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NDESC - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign hit_desc = tbl[hit_idx];
endmodule

// File: rtl/rmp_addr_calc.sv
module rmp_addr_calc import rmp_pkg::*; #(
  parameter int WB_LOG2 = 3
) (
  input  rmp_mode_e          mode,
  input  logic               vec_phase,
  input  logic [RMP_AW-1:0]  pv,
  input  logic [RMP_AW-1:0]  vec,
  input  logic [RMP_SHW-1:0] shift,
  input  logic [RMP_AW-1:0]  s,
  input  logic [RMP_AW-1:0]  entry,
  output logic [RMP_AW-1:0]  addr
);
  // shifts and adds only; no multiplier, no divider
  always_comb begin
    if (vec_phase) begin
      addr = vec + (s << WB_LOG2);
    end else begin
      unique case (mode)
        MODE_STRIDE: addr = pv + (s << shift);
        MODE_INDIR:  addr = pv + (entry << shift);
        default:     addr = pv + (s << WB_LOG2);
      endcase
    end
  end
endmodule

// File: rtl/rmp_line_buf.sv
module rmp_line_buf #(
  parameter int DEPTH = 256,
  parameter int DW    = 64,
  parameter int AB    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AB-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AB-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/shadow_remap_engine.sv
module shadow_remap_engine import rmp_pkg::*; #(
  parameter int                NDESC      = 8,
  parameter int                LINE_WORDS = 16,
  parameter int                WORD_BYTES = 8,
  parameter int                DATA_W     = 64,
  parameter logic [RMP_AW-1:0] DRAM_TOP   = 32'h4000_0000,
  parameter int                IDX_W      = $clog2(NDESC),
  parameter int                TAG_W      = $clog2(LINE_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_sel,
  input  logic               cfg_en,
  input  logic [1:0]         cfg_mode,
  input  logic [RMP_SHW-1:0] cfg_shift,
  input  logic [RMP_AW-1:0]  cfg_lo,
  input  logic [RMP_AW-1:0]  cfg_hi,
  input  logic [RMP_AW-1:0]  cfg_pv,
  input  logic [RMP_AW-1:0]  cfg_vec,
  input  logic               req_valid,
  input  logic [RMP_AW-1:0]  req_addr,
  output logic               req_ready,
  output logic               phys_valid,
  output logic [RMP_AW-1:0]  phys_addr,
  output logic               err_valid,
  output logic               fetch_valid,
  output logic [RMP_AW-1:0]  fetch_addr,
  output logic [TAG_W-1:0]   fetch_tag,
  output logic               fetch_vec,
  input  logic               ret_valid,
  input  logic [TAG_W-1:0]   ret_tag,
  input  logic               ret_vec,
  input  logic [DATA_W-1:0]  ret_data,
  output logic               line_valid,
  output logic [TAG_W-1:0]   line_idx,
  output logic [DATA_W-1:0]  line_data,
  output logic               line_last
);
  localparam int               WB_LOG2   = $clog2(WORD_BYTES);
  localparam int               CNT_W     = TAG_W + 1;
  localparam int               BUF_DEPTH = NDESC * 2 * LINE_WORDS;
  localparam int               BUF_AB    = IDX_W + 1 + TAG_W;
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(LINE_WORDS);
  localparam logic [TAG_W-1:0] LAST_IDX  = TAG_W'(LINE_WORDS - 1);

  rmp_state_e         state;
  rmp_desc_t          cfg_word;
  logic               tbl_hit;
  logic [IDX_W-1:0]   tbl_idx;
  rmp_desc_t          hit_desc;

  rmp_mode_e          cur_mode;
  logic [RMP_AW-1:0]  cur_pv, cur_vec, s0;
  logic [RMP_SHW-1:0] cur_shift;
  logic [IDX_W-1:0]   cur_idx;
  logic [CNT_W-1:0]   iss_cnt, rcv_cnt, drn_cnt;
  logic               p_valid, p_vec;
  logic [TAG_W-1:0]   p_tag;
  logic               d_valid;
  logic [TAG_W-1:0]   d_idx;

  logic               accept, below, gathering;
  logic [BUF_AB-1:0]  buf_raddr, buf_waddr;
  logic [DATA_W-1:0]  buf_rdata;
  logic [RMP_AW-1:0]  calc_addr, calc_s;

  assign cfg_word = '{en: cfg_en, mode: rmp_mode_e'(cfg_mode), shift: cfg_shift,
                      lo: cfg_lo, hi: cfg_hi, pv: cfg_pv, vec: cfg_vec};

  rmp_desc_table #(.NDESC(NDESC), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
    .look_addr(req_addr), .hit(tbl_hit), .hit_idx(tbl_idx), .hit_desc(hit_desc)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign below     = req_addr < DRAM_TOP;
  assign gathering = (state == ST_VEC) || (state == ST_VWAIT) ||
                     (state == ST_DATA) || (state == ST_DWAIT);

  assign buf_waddr = {cur_idx, ret_vec, ret_tag};
  assign buf_raddr = (state == ST_DRAIN) ? {cur_idx, 1'b0, drn_cnt[TAG_W-1:0]}
                                         : {cur_idx, 1'b1, iss_cnt[TAG_W-1:0]};

  rmp_line_buf #(.DEPTH(BUF_DEPTH), .DW(DATA_W), .AB(BUF_AB)) u_buf (
    .clk(clk), .we(ret_valid && gathering), .waddr(buf_waddr), .wdata(ret_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  assign calc_s = s0 + {{(RMP_AW-TAG_W){1'b0}}, p_tag};

  rmp_addr_calc #(.WB_LOG2(WB_LOG2)) u_calc (
    .mode(cur_mode), .vec_phase(p_vec), .pv(cur_pv), .vec(cur_vec), .shift(cur_shift),
    .s(calc_s), .entry(buf_rdata[RMP_AW-1:0]), .addr(calc_addr)
  );

  // control: classify, issue words, collect, drain
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phys_valid <= 1'b0;
      phys_addr  <= '0;
      err_valid  <= 1'b0;
      cur_mode   <= MODE_PAGE;
      cur_pv     <= '0;
      cur_vec    <= '0;
      cur_shift  <= '0;
      cur_idx    <= '0;
      s0         <= '0;
      iss_cnt    <= '0;
      rcv_cnt    <= '0;
      drn_cnt    <= '0;
      p_valid    <= 1'b0;
      p_vec      <= 1'b0;
      p_tag      <= '0;
      d_valid    <= 1'b0;
      d_idx      <= '0;
    end else begin
      phys_valid <= 1'b0;
      err_valid  <= 1'b0;
      p_valid    <= 1'b0;
      d_valid    <= 1'b0;
      if (ret_valid && gathering) rcv_cnt <= rcv_cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (below) begin
              phys_valid <= 1'b1;
              phys_addr  <= req_addr;
            end else if (tbl_hit) begin
              cur_mode  <= hit_desc.mode;
              cur_pv    <= hit_desc.pv;
              cur_vec   <= hit_desc.vec;
              cur_shift <= hit_desc.shift;
              cur_idx   <= tbl_idx;
              s0        <= (req_addr - hit_desc.lo) >> WB_LOG2;
              iss_cnt   <= '0;
              rcv_cnt   <= '0;
              state     <= (hit_desc.mode == MODE_INDIR) ? ST_VEC : ST_DATA;
            end else begin
              err_valid <= 1'b1;
            end
          end
        end
        ST_VEC, ST_DATA: begin
          if (iss_cnt == FULL) begin
            iss_cnt <= '0;
            state   <= (state == ST_VEC) ? ST_VWAIT : ST_DWAIT;
          end else begin
            p_valid <= 1'b1;
            p_vec   <= (state == ST_VEC);
            p_tag   <= iss_cnt[TAG_W-1:0];
            iss_cnt <= iss_cnt + 1'b1;
          end
        end
        ST_VWAIT: begin
          if (rcv_cnt == FULL) begin
            rcv_cnt <= '0;
            state   <= ST_DATA;
          end
        end
        ST_DWAIT: begin
          if (rcv_cnt == FULL) begin
            rcv_cnt <= '0;
            drn_cnt <= '0;
            state   <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (drn_cnt == FULL) begin
            drn_cnt <= '0;
            state   <= ST_IDLE;
          end else begin
            d_valid <= 1'b1;
            d_idx   <= drn_cnt[TAG_W-1:0];
            drn_cnt <= drn_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered fetch stage
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
      fetch_tag   <= '0;
      fetch_vec   <= 1'b0;
    end else begin
      fetch_valid <= p_valid;
      fetch_addr  <= calc_addr;
      fetch_tag   <= p_tag;
      fetch_vec   <= p_vec;
    end
  end

  assign line_valid = d_valid;
  assign line_idx   = d_idx;
  assign line_data  = buf_rdata;
  assign line_last  = d_valid && (d_idx == LAST_IDX);

  p_bypass_next_r1: assert property (@(posedge clk) disable iff (rst)
    accept && below |=> phys_valid && (phys_addr == $past(req_addr)));

  p_unmapped_err_r2: assert property (@(posedge clk) disable iff (rst)
    accept && !below && !tbl_hit |=> err_valid && !phys_valid && !fetch_valid);

  p_hit_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    accept && !below && tbl_hit |-> hit_desc.en && (req_addr >= hit_desc.lo) && (req_addr < hit_desc.hi));

  p_tag_ascending_r5: assert property (@(posedge clk) disable iff (rst)
    fetch_valid && $past(fetch_valid) && (fetch_vec == $past(fetch_vec))
      |-> (fetch_tag - $past(fetch_tag)) == TAG_W'(1));

  p_rcv_bound_r7: assert property (@(posedge clk) disable iff (rst)
    rcv_cnt <= FULL);

  p_line_not_with_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> !fetch_valid);

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    fetch_valid || line_valid |-> !req_ready);
endmodule

// File: tb/shadow_remap_engine_test.sv
module shadow_remap_engine_test;
  import rmp_pkg::*;

  localparam int NT = 10;
  localparam logic [31:0] T_ADDR [NT] = '{32'h0000_1000, 32'h3FFF_FF80, 32'h1000_0000,
    32'h4000_0000, 32'h8000_0000, 32'h8000_0080, 32'h8001_0100, 32'h8003_0080,
    32'h9000_0000, 32'h8000_1000};
  localparam int T_KIND [NT] = '{0, 0, 0, 2, 1, 1, 1, 1, 2, 2};
  localparam int T_DESC [NT] = '{0, 0, 0, 0, 0, 0, 1, 2, 0, 0};

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_en = 0;
  logic [2:0] cfg_sel = '0;
  logic [1:0] cfg_mode = '0;
  logic [4:0] cfg_shift = '0;
  logic [31:0] cfg_lo = '0, cfg_hi = '0, cfg_pv = '0, cfg_vec = '0;
  logic req_valid = 0;
  logic [31:0] req_addr = '0;
  logic req_ready, phys_valid, err_valid, fetch_valid, fetch_vec, line_valid, line_last;
  logic [31:0] phys_addr, fetch_addr;
  logic [3:0] fetch_tag, line_idx;
  logic ret_valid = 0, ret_vec = 0;
  logic [3:0] ret_tag = '0;
  logic [63:0] ret_data = '0, line_data;

  shadow_remap_engine uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_mode(cfg_mode), .cfg_shift(cfg_shift), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_pv(cfg_pv), .cfg_vec(cfg_vec), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .phys_valid(phys_valid), .phys_addr(phys_addr),
    .err_valid(err_valid), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_tag(fetch_tag), .fetch_vec(fetch_vec), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .ret_vec(ret_vec), .ret_data(ret_data), .line_valid(line_valid),
    .line_idx(line_idx), .line_data(line_data), .line_last(line_last)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit stray_on = 0;
  int phys_seen = 0;

  logic [31:0] m_lo [8], m_hi [8], m_pv [8], m_vec [8];
  int m_sh [8], m_mode [8];

  always @(negedge clk) if (stray_on && phys_valid) phys_seen++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dword(input logic [31:0] a);
    return {a ^ 32'hA5A5_5A5A, a};
  endfunction

  function automatic logic [63:0] vent(input logic [31:0] s);
    return {32'hFFFF_FFFF, (s * 32'd7 + 32'd3) & 32'h0000_0FFF};
  endfunction

  task automatic cfg_write(input int d, input bit en, input int mode, input int sh,
                           input logic [31:0] lo, hi, pv, vec);
    cfg_we = 1; cfg_sel = 3'(d); cfg_en = en; cfg_mode = 2'(mode); cfg_shift = 5'(sh);
    cfg_lo = lo; cfg_hi = hi; cfg_pv = pv; cfg_vec = vec;
    @(negedge clk);
    cfg_we = 0;
    m_lo[d] = lo; m_hi[d] = hi; m_pv[d] = pv; m_vec[d] = vec; m_sh[d] = sh; m_mode[d] = mode;
  endtask

  task automatic wait_fetch();
    for (int k = 0; k < 40 && !fetch_valid; k++) @(negedge clk);
  endtask

  task automatic run_case(input logic [31:0] addr, input int kind, input int d, input bit mid);
    logic [31:0] pv, vec, lo, s0;
    logic [31:0] ea [16];
    int sh, mode;
    string rq;
    bit early_line;
    req_valid = 1; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    if (kind == 0) begin
      chk("R1 phys_valid", 64'(phys_valid), 64'd1);
      chk("R1 phys_addr", 64'(phys_addr), 64'(addr));
      chk("R1 no error", 64'(err_valid), 64'd0);
      @(negedge clk);
      chk("R1 no fetch", 64'(fetch_valid), 64'd0);
      chk("R1 ready again", 64'(req_ready), 64'd1);
      return;
    end
    if (kind == 2) begin
      chk("R2 err_valid", 64'(err_valid), 64'd1);
      chk("R2 no phys", 64'(phys_valid), 64'd0);
      @(negedge clk);
      chk("R2 pulse ends", 64'(err_valid), 64'd0);
      chk("R2 no fetch", 64'(fetch_valid), 64'd0);
      chk("R2 ready again", 64'(req_ready), 64'd1);
      return;
    end
    pv = m_pv[d]; vec = m_vec[d]; lo = m_lo[d]; sh = m_sh[d]; mode = m_mode[d];
    s0 = (addr - lo) >> 3;
    chk("R8 busy after accept", 64'(req_ready), 64'd0);
    chk("R3 no phys/err on hit", 64'({phys_valid, err_valid}), 64'd0);
    if (mid) begin
      stray_on = 1; phys_seen = 0;
      req_valid = 1; req_addr = 32'h0000_0100;
      cfg_write(d, 1, m_mode[d], m_sh[d], m_lo[d], m_hi[d], m_pv[d] + 32'h0010_0000, m_vec[d]);
    end
    if (mode == 2) begin
      for (int i = 0; i < 16; i++) begin
        wait_fetch();
        chk("R6 index fetch flag", 64'({fetch_valid, fetch_vec}), 64'd3);
        chk("R5 index tag order", 64'(fetch_tag), 64'(i));
        chk("R6 index address", 64'(fetch_addr), 64'(vec + ((s0 + 32'(i)) << 3)));
        @(negedge clk);
      end
      for (int j = 0; j < 16; j++) begin
        int t;
        t = (j * 5) & 15;
        ret_valid = 1; ret_vec = 1; ret_tag = 4'(t); ret_data = vent(s0 + 32'(t));
        @(negedge clk);
      end
      ret_valid = 0; ret_vec = 0;
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] s;
      s = s0 + 32'(i);
      if (mode == 0) ea[i] = pv + (addr - lo) + 32'(8 * i);
      else if (mode == 1) ea[i] = pv + (s << sh);
      else ea[i] = pv + (vent(s)[31:0] << sh);
    end
    rq = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
    for (int i = 0; i < 16; i++) begin
      wait_fetch();
      chk({rq, " data fetch flag"}, 64'({fetch_valid, fetch_vec}), 64'd2);
      chk("R5 data tag order", 64'(fetch_tag), 64'(i));
      chk({rq, mid ? " R9 captured address" : " data address"}, 64'(fetch_addr), 64'(ea[i]));
      @(negedge clk);
    end
    chk("R5 exactly 16 fetches", 64'(fetch_valid), 64'd0);
    early_line = 0;
    for (int j = 0; j < 16; j++) begin
      int t;
      t = 15 - j;
      if (line_valid) early_line = 1;
      ret_valid = 1; ret_vec = 0; ret_tag = 4'(t); ret_data = dword(ea[t]);
      @(negedge clk);
    end
    ret_valid = 0;
    chk("R7 no line before all words", 64'(early_line), 64'd0);
    for (int k = 0; k < 40 && !line_valid; k++) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      chk("R7 line beat valid", 64'(line_valid), 64'd1);
      chk("R7 line index", 64'(line_idx), 64'(i));
      chk("R7 line word by tag", line_data, dword(ea[i]));
      chk("R7 line_last", 64'(line_last), 64'(i == 15));
      if (i == 15) req_valid = 0;
      @(negedge clk);
    end
    chk("R7 line ends", 64'(line_valid), 64'd0);
    if (mid) begin
      stray_on = 0;
      chk("R8 stray request ignored", 64'(phys_seen), 64'd0);
    end
    chk("R8 ready after line", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_pv[i] = '0; m_vec[i] = '0; m_sh[i] = 0; m_mode[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", 64'(req_ready), 64'd1);
    chk("R10 outputs idle", 64'({phys_valid, err_valid, fetch_valid, line_valid}), 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R10 outputs idle after reset", 64'({phys_valid, err_valid, fetch_valid, line_valid}), 64'd0);

    cfg_write(0, 1, 0, 0, 32'h8000_0000, 32'h8000_1000, 32'h0001_0000, 32'h0);
    cfg_write(1, 1, 1, 6, 32'h8001_0000, 32'h8002_0000, 32'h0020_0000, 32'h0);
    cfg_write(2, 1, 2, 3, 32'h8003_0000, 32'h8003_1000, 32'h0030_0000, 32'h0040_0000);
    cfg_write(3, 1, 1, 4, 32'h8001_0000, 32'h8001_1000, 32'h0050_0000, 32'h0);
    cfg_write(4, 1, 1, 4, 32'h1000_0000, 32'h1000_1000, 32'h0060_0000, 32'h0);
    cfg_write(5, 0, 1, 4, 32'h9000_0000, 32'h9000_1000, 32'h0070_0000, 32'h0);

    for (int i = 0; i < NT; i++) run_case(T_ADDR[i], T_KIND[i], T_DESC[i], 1'b0);

    // R9: rewrite during gather, then the new value applies to the next request
    run_case(32'h8003_0100, 1, 2, 1'b1);
    run_case(32'h8003_0100, 1, 2, 1'b0);
    // R3: highest index, strided with a small shift
    cfg_write(7, 1, 1, 2, 32'h8004_0000, 32'h8004_0400, 32'h0080_0000, 32'h0);
    run_case(32'h8004_0380, 1, 7, 1'b0);
    run_case(32'h8004_0400, 2, 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule